// File: doc/BRIEF.md
# Parallel Display Write Master

This block sits on the host side of an 8080-style parallel bus and pushes words into a display controller. An upstream source offers one 18-bit word at a time. Each word carries a flag that marks it as a command code or as a data/parameter word, and a second flag that marks the last word of a transaction. The block accepts one word whenever it is not busy. It turns each word into exactly one write-strobe pulse. Low and high strobe times are set from two configuration inputs, counted in system clocks.

A transaction is a command word followed by any number of parameter words. Chip select falls when the first word is accepted. It stays low across the whole group and rises only after the pulse of the word flagged as last. The data/command line follows each word. The bus tristate enable is asserted only from the strobe's falling edge until one clock after its rising edge. The read strobe is never used and stays high.

Top module: `par_wr_master`

## Requirements
- R1: After reset, cs_n=1, wr_n=1, rd_n=1, dq_oe=0 and busy=0.
- R2: dc is 0 during the pulse of a word offered with s_is_data=0 (command) and 1 for a word offered with s_is_data=1 (data or parameter).
- R3: wr_n stays low for exactly cfg_low clocks; a value of 0 is treated as 1.
- R4: After wr_n rises, it stays high for exactly cfg_high clocks before busy falls; a value of 0 is treated as 1.
- R5: For the one clock before wr_n falls, wr_n is high, cs_n is low and dc already holds the word's value.
- R6: dq_oe is 1 on every clock where wr_n is low and on the first clock after wr_n rises, and 0 on the clock after that. dq_out and dc do not change while wr_n is low.
- R7: rd_n is 1 on every clock.
- R8: cs_n stays low between words of a transaction. It goes high on the clock busy falls after a word offered with s_last=1, and stays low after a word with s_last=0.
- R9: busy rises on the clock after a word is accepted (s_valid with busy=0). s_valid asserted while busy is 1 has no effect: it starts no pulse.
- R10: dq_out at the rising edge of wr_n equals the accepted s_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| s_valid | input | 1 | Upstream word is offered |
| s_word | input | 18 | Word to write |
| s_is_data | input | 1 | 1 = data/parameter, 0 = command |
| s_last | input | 1 | Word ends the transaction |
| busy | output | 1 | A write cycle is in progress; input is held off |
| cfg_low | input | 8 | Strobe low time in clocks |
| cfg_high | input | 8 | Strobe high time in clocks |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select |
| rd_n | output | 1 | Read strobe, held high |
| wr_n | output | 1 | Write strobe, active low |
| dq_out | output | 18 | Bus drive value |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The words sent are a single command with no parameters, a command followed by several parameters, and back-to-back transactions. Together they separate a chip select that rises per word from one that rises per group. Alternating data patterns such as all-ones, all-zeros and walking bits expose stuck or swapped bus lines. Strobe timing is tried at minimum (zero and one), middle and uneven low/high counts, which shows off-by-one errors in either counter. A burst of offers held while busy shows whether held-off input leaks into an extra pulse.

// File: rtl/par_wr_master.sv
module par_wr_master #(
  parameter int DW = 18,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_word,
  input  logic          s_is_data,
  input  logic          s_last,
  output logic          busy,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_high,
  output logic          cs_n,
  output logic          dc,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH} st_t;
  localparam logic [CW-1:0] ONE = CW'(1);

  st_t           st;
  logic [CW-1:0] cnt;
  logic          cs_q, dc_q, last_q, hold_q;
  logic [DW-1:0] dat_q;

  wire [CW-1:0] lo_n = (cfg_low  == '0) ? ONE : cfg_low;
  wire [CW-1:0] hi_n = (cfg_high == '0) ? ONE : cfg_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      cs_q   <= 1'b1;
      dc_q   <= 1'b0;
      last_q <= 1'b0;
      hold_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (s_valid) begin
          st     <= S_SETUP;
          cs_q   <= 1'b0;
          dc_q   <= s_is_data;
          dat_q  <= s_word;
          last_q <= s_last;
        end
        S_SETUP: begin
          st  <= S_LOW;
          cnt <= lo_n - ONE;
        end
        S_LOW: if (cnt == '0) begin
          st     <= S_HIGH;
          cnt    <= hi_n - ONE;
          hold_q <= 1'b1;
        end else cnt <= cnt - ONE;
        S_HIGH: begin
          hold_q <= 1'b0;
          if (cnt == '0) begin
            st <= S_IDLE;
            if (last_q) cs_q <= 1'b1;
          end else cnt <= cnt - ONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign cs_n   = cs_q;
  assign dc     = dc_q;
  assign rd_n   = 1'b1;
  assign wr_n   = (st != S_LOW);
  assign dq_out = dat_q;
  assign dq_oe  = (st == S_LOW) || hold_q;

  assert_oe_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !cs_n);
  assert_low_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> dq_oe);
  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(dq_out) && $stable(dc)));
  assert_fall_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($past(!cs_n) && $past(busy) && $stable(dc)));
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !busy) |=> busy);

endmodule

// File: tb/sim_par_wr_master.sv
module sim_par_wr_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_is_data = 1'b0, s_last = 1'b0;
  logic [17:0] s_word = '0;
  logic [7:0] cfg_low = 8'd2, cfg_high = 8'd2;
  logic busy, cs_n, dc, rd_n, wr_n, dq_oe;
  logic [17:0] dq_out;

  int total = 0, bad = 0, sent = 0, seen = 0;
  logic [19:0] expq[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  par_wr_master u0 (.clk, .rst_n, .s_valid, .s_word, .s_is_data, .s_last, .busy,
    .cfg_low, .cfg_high, .cs_n, .dc, .rd_n, .wr_n, .dq_out, .dq_oe);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [17:0] w, input bit isd, input bit lst, input int hold_extra);
    @(negedge clk);
    while (busy) @(negedge clk);
    s_valid = 1; s_word = w; s_is_data = isd; s_last = lst;
    expq.push_back({lst, isd, w});
    sent++;
    @(negedge clk);
    s_word = ~w; s_is_data = ~isd;
    for (int i = 0; i < hold_extra; i++) @(negedge clk);
    s_valid = 0;
  endtask

  // monitor: samples at negedge
  initial begin
    logic pw = 1, pbusy = 0, pcs = 1, pdc = 0, pl = 0, in_high = 0, chk_oe2 = 0;
    logic [19:0] it;
    logic cur_last = 0;
    int lowc = 0, highc = 0;
    logic ldc = 0, loe = 1;
    logic [17:0] ldq = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (chk_oe2) begin
        chk(dq_oe == 0, "R6 oe release", dq_oe, 0);
        chk_oe2 = 0;
      end
      if (!wr_n) begin
        if (pw) begin
          chk(pcs == 0 && pdc == dc && pbusy, "R5 setup", {pcs, pdc}, {1'b0, dc});
          lowc = 0; loe = 1;
        end
        lowc++; ldc = dc; ldq = dq_out; loe = loe & dq_oe;
      end else if (!pw) begin
        seen++;
        if (expq.size() == 0) chk(0, "R9 extra pulse", seen, sent);
        else begin
          it = expq.pop_front();
          cur_last = it[19];
          chk(ldq == it[17:0], "R10 data", ldq, it[17:0]);
          chk(ldc == it[18], "R2 dc", ldc, it[18]);
          chk(lowc == ((cfg_low == 0) ? 1 : cfg_low), "R3 low width", lowc, cfg_low);
          chk(loe && dq_oe && !cs_n && rd_n, "R6 R7 drive", {loe, dq_oe, cs_n, rd_n}, 4'b1101);
        end
        highc = 0; in_high = 1; chk_oe2 = 1;
      end
      if (in_high && busy) highc++;
      if (in_high && !busy && pbusy) begin
        chk(highc == ((cfg_high == 0) ? 1 : cfg_high), "R4 high width", highc, cfg_high);
        chk(cs_n == cur_last, "R8 cs", cs_n, cur_last);
        in_high = 0;
      end
      pw = wr_n; pbusy = busy; pcs = cs_n; pdc = dc;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rd_n && !dq_oe && !busy, "R1 reset", {cs_n, wr_n, rd_n, dq_oe, busy}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && wr_n && rd_n && !dq_oe && !busy, "R1 after release", {cs_n, wr_n, rd_n, dq_oe, busy}, 5'b11100);
    // single command, minimum timing (zero treated as one)
    cfg_low = 0; cfg_high = 0;
    send(18'h0002C, 0, 1, 0);
    // command plus parameters, middle timing
    cfg_low = 3; cfg_high = 2;
    send(18'h0002A, 0, 0, 0);
    send(18'h3FFFF, 1, 0, 0);
    send(18'h00000, 1, 0, 0);
    send(18'h15555, 1, 1, 0);
    // uneven timing, walking bits
    cfg_low = 1; cfg_high = 5;
    send(18'h00036, 0, 0, 0);
    for (int b = 0; b < 18; b += 3) send(18'h1 << b, 1, b == 15, 0);
    // R9: offers held while busy
    cfg_low = 4; cfg_high = 1;
    send(18'h2AAAA, 0, 0, 3);
    send(18'h12345, 1, 1, 2);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(expq.size() == 0 && seen == sent, "R9 pulse count", seen, sent);
    chk(cs_n && !busy && rd_n, "R8 R7 idle", {cs_n, busy, rd_n}, 3'b101);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule